// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counters, each made of an 8-bit low byte and an 8-bit high byte. A byte-wide write port loads a configuration byte, two extended mode bits, the four count bytes, the two run bits and the two overflow flags. Each timer advances on every clock or on falling edges of its own external count pin. It can also be gated by a level pin, so that it runs only while that pin is high.

A 3-bit mode code picks how the two bytes of a timer work together. Code 000 gives a 13-bit counter, where the low five bits of the low byte divide by 32 before the high byte advances. Code 001 gives a flat 16-bit counter. Code 010 gives an 8-bit counter that reloads from the high byte. Code 011 on timer 0 splits it into two independent 8-bit counters. The upper split byte borrows timer 1's run bit and overflow flag, and timer 1 stops. All other codes freeze the counter. An overflow flag per timer goes to the surrounding interrupt logic.

Top module: `dual_timer`

## Requirements
- R1: After reset all four count bytes, both run bits, both flags and all mode bits read zero.
- R2: Write address selects the target: 0 configuration byte, 1 extended mode bits, 2 low byte 0, 3 high byte 0, 4 low byte 1, 5 high byte 1, 6 run bits (bit 0 timer 0, bit 1 timer 1), 7 flags (bit 0 timer 0, bit 1 timer 1). A byte write overrides a count to that byte in the same cycle.
- R3: Configuration bits 1:0 are mode bits for timer 0 and bits 5:4 for timer 1. Bit 0 of the extended register is the top mode bit of timer 0 and bit 4 is that of timer 1. Code 000 counts {high byte, low[4:0]} as 13 bits, and low[7:5] keep their value.
- R4: Code 001 counts {high, low} as one 16-bit value.
- R5: Code 010 increments the low byte, and on passing 0xFF loads it from the high byte, which is unchanged.
- R6: Timer 0 with code 011: the low byte counts under timer 0's run, source and gate controls. The high byte counts every clock while timer 1's run bit is set, and its wrap sets timer 1's flag.
- R7: Codes 100, 101, 110 and 111 hold both bytes of the timer unchanged.
- R8: Configuration bit 2 (timer 0) or 6 (timer 1) set to 1 counts falling edges of the count pin after a two-stage synchronizer, one count per edge. Set to 0, the timer counts clocks.
- R9: Configuration bit 3 (timer 0) or 7 (timer 1) set to 1 lets the timer count only while its gate pin, synchronized through two stages, is high and its run bit is set.
- R10: A flag sets on wrap to zero of the whole counter (codes 000, 001) or of the low byte (010, split low byte). It stays set until a flag write clears it, and a set in the same cycle wins over that clear.
- R11: Timer 1 holds its bytes while timer 0 is in code 011, and also while its own code is 011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select |
| wrData | input | 8 | Write data |
| cntPin | input | 2 | External count pins, bit n for timer n |
| gatePin | input | 2 | External gate pins, bit n for timer n |
| tl0 | output | 8 | Timer 0 low byte |
| th0 | output | 8 | Timer 0 high byte |
| tl1 | output | 8 | Timer 1 low byte |
| th1 | output | 8 | Timer 1 high byte |
| tfFlag | output | 2 | Overflow flags, bit n for timer n |

## Verification
A table runs timer 0 for a fixed number of clocks under each mode code. Start values sit either well away from the byte and prescaler boundaries or just below them. This separates a plain increment from a carry into the high byte, a 13-bit versus a 16-bit wrap, a reload, and a freeze on the reserved codes. A start value with the low byte's upper three bits set shows whether the prescaled mode leaves them alone. Directed runs then pulse the count pin and the gate pin so that exact counts reveal synchronizer latency and edge detection. They also drive both halves of split mode with separate run bits, and place a flag clear on the same edge as an overflow.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  localparam int BYTE_W      = 8;
  localparam int PRE_BITS    = 5;
  localparam int SYNC_STAGES = 2;
  localparam int NUM_TMR     = 2;
  localparam int ADDR_W      = 3;

  localparam logic [2:0] MODE_PRE    = 3'b000;
  localparam logic [2:0] MODE_WIDE   = 3'b001;
  localparam logic [2:0] MODE_RELOAD = 3'b010;
  localparam logic [2:0] MODE_SPLIT  = 3'b011;
  localparam logic [2:0] MODE_HOLD   = 3'b110;

  localparam logic [ADDR_W-1:0] REG_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] REG_EXT  = 3'd1;
  localparam logic [ADDR_W-1:0] REG_TL0  = 3'd2;
  localparam logic [ADDR_W-1:0] REG_TH0  = 3'd3;
  localparam logic [ADDR_W-1:0] REG_TL1  = 3'd4;
  localparam logic [ADDR_W-1:0] REG_TH1  = 3'd5;
  localparam logic [ADDR_W-1:0] REG_RUN  = 3'd6;
  localparam logic [ADDR_W-1:0] REG_FLAG = 3'd7;

  typedef struct packed {
    logic [2:0]         code0;
    logic [2:0]         code1;
    logic               stepT0;
    logic               stepT1;
    logic               stepHiSplit;
    logic [BYTE_W-1:0]  loadData;
    logic               ldTl0;
    logic               ldTh0;
    logic               ldTl1;
    logic               ldTh1;
    logic               flagWr;
    logic [NUM_TMR-1:0] flagVal;
  } tmr_strobe_t;

  // Returns {wrap, nextHigh, nextLow} for one count step.
  function automatic logic [2*BYTE_W:0] advance(input logic [2:0] code,
                                                input logic [BYTE_W-1:0] hi,
                                                input logic [BYTE_W-1:0] lo);
    logic [BYTE_W+PRE_BITS:0] pre;
    logic [2*BYTE_W:0]        wide;
    logic [BYTE_W:0]          half;
    logic [2*BYTE_W:0]        res;
    res = {1'b0, hi, lo};
    case (code)
      MODE_PRE: begin
        pre = {1'b0, hi, lo[PRE_BITS-1:0]} + 1'b1;
        res = {pre[BYTE_W+PRE_BITS], pre[BYTE_W+PRE_BITS-1 -: BYTE_W],
               lo[BYTE_W-1:PRE_BITS], pre[PRE_BITS-1:0]};
      end
      MODE_WIDE: begin
        wide = {1'b0, hi, lo} + 1'b1;
        res  = wide;
      end
      MODE_RELOAD: begin
        half = {1'b0, lo} + 1'b1;
        res  = half[BYTE_W] ? {1'b1, hi, hi} : {1'b0, hi, half[BYTE_W-1:0]};
      end
      MODE_SPLIT: begin
        half = {1'b0, lo} + 1'b1;
        res  = {half[BYTE_W], hi, half[BYTE_W-1:0]};
      end
      default: res = {1'b0, hi, lo};
    endcase
    return res;
  endfunction
endpackage

// File: rtl/dual_timer_ctrl.sv
module dual_timer_ctrl
  import dual_timer_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic [NUM_TMR-1:0]    cntPin,
  input  logic [NUM_TMR-1:0]    gatePin,
  output logic [BYTE_W-1:0]     modeByte,
  output logic [NUM_TMR-1:0]    auxBits,
  output logic [NUM_TMR-1:0]    runBits,
  output tmr_strobe_t           strobe
);
  logic [NUM_TMR-1:0] step;
  logic [2:0]         code [NUM_TMR];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeByte <= '0;
      auxBits  <= '0;
      runBits  <= '0;
    end else if (wrEn) begin
      if (wrAddr == REG_CFG) modeByte <= wrData;
      if (wrAddr == REG_EXT) auxBits  <= {wrData[4], wrData[0]};
      if (wrAddr == REG_RUN) runBits  <= wrData[NUM_TMR-1:0];
    end
  end

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    logic [SYNC_STAGES-1:0] cntSync;
    logic [SYNC_STAGES-1:0] gateSync;
    logic                   cntLast;
    logic                   fallEdge;
    logic                   srcExt;
    logic                   gateOn;
    logic                   enable;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntSync  <= '0;
        gateSync <= '0;
        cntLast  <= 1'b0;
      end else begin
        cntSync  <= {cntSync[SYNC_STAGES-2:0], cntPin[g]};
        gateSync <= {gateSync[SYNC_STAGES-2:0], gatePin[g]};
        cntLast  <= cntSync[SYNC_STAGES-1];
      end
    end

    assign fallEdge = cntLast & ~cntSync[SYNC_STAGES-1];
    assign srcExt   = modeByte[4*g+2];
    assign gateOn   = modeByte[4*g+3];
    assign code[g]  = {auxBits[g], modeByte[4*g+1 -: 2]};
    assign enable   = runBits[g] & (~gateOn | gateSync[SYNC_STAGES-1]);
    assign step[g]  = enable & (srcExt ? fallEdge : 1'b1);
  end

  always_comb begin
    strobe             = '0;
    strobe.code0       = code[0];
    strobe.code1       = code[1];
    strobe.stepT0      = step[0];
    strobe.stepT1      = step[1] & (code[0] != MODE_SPLIT);
    strobe.stepHiSplit = (code[0] == MODE_SPLIT) & runBits[1];
    strobe.loadData    = wrData;
    strobe.ldTl0       = wrEn & (wrAddr == REG_TL0);
    strobe.ldTh0       = wrEn & (wrAddr == REG_TH0);
    strobe.ldTl1       = wrEn & (wrAddr == REG_TL1);
    strobe.ldTh1       = wrEn & (wrAddr == REG_TH1);
    strobe.flagWr      = wrEn & (wrAddr == REG_FLAG);
    strobe.flagVal     = wrData[NUM_TMR-1:0];
  end
endmodule

// File: rtl/dual_timer_dp.sv
module dual_timer_dp
  import dual_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  tmr_strobe_t        strobe,
  output logic [BYTE_W-1:0]  tl0,
  output logic [BYTE_W-1:0]  th0,
  output logic [BYTE_W-1:0]  tl1,
  output logic [BYTE_W-1:0]  th1,
  output logic [NUM_TMR-1:0] tfFlag
);
  logic [2*BYTE_W:0] next0;
  logic [2*BYTE_W:0] next1;
  logic [BYTE_W:0]   hiNext;
  logic [2:0]        code1Eff;

  assign code1Eff = (strobe.code1 == MODE_SPLIT) ? MODE_HOLD : strobe.code1;
  assign next0    = advance(strobe.code0, th0, tl0);
  assign next1    = advance(code1Eff, th1, tl1);
  assign hiNext   = {1'b0, th0} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tl0    <= '0;
      th0    <= '0;
      tl1    <= '0;
      th1    <= '0;
      tfFlag <= '0;
    end else begin
      if (strobe.stepT0) begin
        tl0 <= next0[BYTE_W-1:0];
        th0 <= next0[2*BYTE_W-1:BYTE_W];
      end
      if (strobe.stepHiSplit) th0 <= hiNext[BYTE_W-1:0];
      if (strobe.stepT1) begin
        tl1 <= next1[BYTE_W-1:0];
        th1 <= next1[2*BYTE_W-1:BYTE_W];
      end
      if (strobe.ldTl0) tl0 <= strobe.loadData;
      if (strobe.ldTh0) th0 <= strobe.loadData;
      if (strobe.ldTl1) tl1 <= strobe.loadData;
      if (strobe.ldTh1) th1 <= strobe.loadData;

      if (strobe.flagWr) tfFlag <= strobe.flagVal;
      if (strobe.stepT0 && next0[2*BYTE_W]) tfFlag[0] <= 1'b1;
      if (strobe.stepHiSplit && hiNext[BYTE_W]) tfFlag[1] <= 1'b1;
      if (strobe.stepT1 && next1[2*BYTE_W]) tfFlag[1] <= 1'b1;
    end
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dual_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic [1:0]  cntPin,
  input  logic [1:0]  gatePin,
  output logic [7:0]  tl0,
  output logic [7:0]  th0,
  output logic [7:0]  tl1,
  output logic [7:0]  th1,
  output logic [1:0]  tfFlag
);
  tmr_strobe_t        strobe;
  logic [BYTE_W-1:0]  modeByte;
  logic [NUM_TMR-1:0] auxBits;
  logic [NUM_TMR-1:0] runBits;

  dual_timer_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cntPin(cntPin), .gatePin(gatePin), .modeByte(modeByte),
    .auxBits(auxBits), .runBits(runBits), .strobe(strobe)
  );

  dual_timer_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tl0(tl0), .th0(th0),
    .tl1(tl1), .th1(th1), .tfFlag(tfFlag)
  );
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [2:0] wrAddr,
  input logic [7:0] wrData,
  input logic [7:0] tl0,
  input logic [7:0] th0,
  input logic [7:0] tl1,
  input logic [7:0] th1,
  input logic [1:0] tfFlag,
  input logic [7:0] modeByte,
  input logic [1:0] auxBits,
  input logic [1:0] runBits
);
  logic [2:0] code0;
  logic [2:0] code1;
  logic       wrT0;
  logic       wrT1;
  assign code0 = {auxBits[0], modeByte[1:0]};
  assign code1 = {auxBits[1], modeByte[5:4]};
  assign wrT0  = wrEn && (wrAddr == 3'd2 || wrAddr == 3'd3);
  assign wrT1  = wrEn && (wrAddr == 3'd4 || wrAddr == 3'd5);

  // R10
  flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(tfFlag[0]) || $fell(tfFlag[1])) |-> $past(wrEn && wrAddr == 3'd7));

  // R2
  low0_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 3'd2) |=> (tl0 == $past(wrData)));

  // R7
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (code0[2] && !wrT0) |=> ($stable(tl0) && $stable(th0)));

  // R11
  t1_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((code0 == 3'b011 || code1 == 3'b011) && !wrT1) |=> ($stable(tl1) && $stable(th1)));

  // R4
  wide_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (code0 == 3'b001 && runBits[0] && !modeByte[2] && !modeByte[3] && !wrT0)
      |=> ({th0, tl0} == $past({th0, tl0}) + 16'd1));
endmodule

bind dual_timer dual_timer_chk chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .tl0(tl0), .th0(th0), .tl1(tl1), .th1(th1), .tfFlag(tfFlag),
  .modeByte(modeByte), .auxBits(auxBits), .runBits(runBits)
);

// File: tb/dual_timer_tb.sv
`timescale 1ns/1ps
module dual_timer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] cntPin = '0;
  logic [1:0] gatePin = '0;
  logic [7:0] tl0, th0, tl1, th1;
  logic [1:0] tfFlag;
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dual_timer dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cntPin(cntPin), .gatePin(gatePin), .tl0(tl0), .th0(th0), .tl1(tl1),
    .th1(th1), .tfFlag(tfFlag)
  );

  // {code, startHigh, startLow, counts, expHigh, expLow, expFlag}
  localparam logic [55:0] VEC [11] = '{
    56'h01_00_00_0A_00_0A_00,  // R4 plain
    56'h01_00_FE_03_01_01_00,  // R4 carry
    56'h01_FF_FE_03_00_01_01,  // R4 wrap, R10
    56'h00_00_1E_03_01_01_00,  // R3 prescale carry
    56'h00_FF_1E_03_00_01_01,  // R3 13-bit wrap, R10
    56'h00_00_E0_03_00_E3_00,  // R3 upper low bits kept
    56'h02_F0_FD_04_F0_F1_01,  // R5 reload, R10
    56'h02_80_10_04_80_14_00,  // R5 plain
    56'h06_12_34_04_12_34_00,  // R7 code 110
    56'h04_12_34_04_12_34_00,  // R7 code 100
    56'h07_AB_CD_05_AB_CD_00   // R7 code 111
  };

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 tl0", tl0, 0); check("R1 th0", th0, 0);
    check("R1 tl1", tl1, 0); check("R1 th1", th1, 0);
    check("R1 flags", tfFlag, 0);

    for (int i = 0; i < 11; i++) begin
      logic [7:0] code, hi, lo, n, eh, el, ef;
      {code, hi, lo, n, eh, el, ef} = VEC[i];
      wr(3'd6, 8'h00);
      wr(3'd7, 8'h00);
      wr(3'd0, {6'b0, code[1:0]});
      wr(3'd1, {7'b0, code[2]});
      wr(3'd2, lo);
      wr(3'd3, hi);
      wr(3'd6, 8'h01);
      idle(n - 1);
      wr(3'd6, 8'h00);
      check($sformatf("R3-7 vec%0d high", i), th0, eh);
      check($sformatf("R3-7 vec%0d low", i), tl0, el);
      check($sformatf("R10 vec%0d flag", i), tfFlag[0], ef);
    end

    // R2 write overrides count
    wr(3'd0, 8'h01); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd6, 8'h01); idle(3);
    wr(3'd2, 8'h55);
    wr(3'd6, 8'h00);
    check("R2 write wins", tl0, 8'h56);
    wr(3'd3, 8'h9A);
    check("R2 high write", th0, 8'h9A);

    // R8 external falling edges
    cntPin[0] = 1'b1;
    wr(3'd0, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    idle(4);
    wr(3'd6, 8'h01);
    for (int k = 0; k < 3; k++) begin
      cntPin[0] = 1'b0; idle(4);
      cntPin[0] = 1'b1; idle(4);
    end
    idle(4);
    wr(3'd6, 8'h00);
    check("R8 edge count", tl0, 3);

    // R9 gating
    wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    gatePin[0] = 1'b0;
    wr(3'd6, 8'h01); idle(8);
    check("R9 gate low holds", tl0, 0);
    gatePin[0] = 1'b1; idle(10);
    gatePin[0] = 1'b0; idle(6);
    check("R9 gate window", tl0, 10);
    wr(3'd6, 8'h00);

    // R6 split mode, R11 timer 1 stopped
    wr(3'd7, 8'h00);
    wr(3'd0, 8'h13); wr(3'd1, 8'h00);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFE); wr(3'd4, 8'h10); wr(3'd5, 8'h20);
    wr(3'd6, 8'h03); idle(2); wr(3'd6, 8'h00);
    check("R6 split low", tl0, 8'h01);
    check("R6 split high", th0, 8'h01);
    check("R6 split flags", tfFlag, 2'b11);
    check("R11 tl1 held", tl1, 8'h10);
    check("R11 th1 held", th1, 8'h20);
    wr(3'd7, 8'h00);
    check("R10 clear", tfFlag, 0);
    wr(3'd6, 8'h02); idle(2); wr(3'd6, 8'h00);
    check("R6 high on run1", th0, 8'h04);
    check("R6 low idle", tl0, 8'h01);

    // R5 timer 1 reload, R3 timer 1 mode bits
    wr(3'd0, 8'h21); wr(3'd4, 8'hFE); wr(3'd5, 8'hFE);
    wr(3'd6, 8'h02); idle(2); wr(3'd6, 8'h00);
    check("R5 t1 reload low", tl1, 8'hFF);
    check("R10 t1 flag", tfFlag, 2'b10);
    check("R5 t0 untouched", tl0, 8'h01);

    // R11 own code 011 holds
    wr(3'd0, 8'h31);
    wr(3'd6, 8'h02); idle(4); wr(3'd6, 8'h00);
    check("R11 own split", tl1, 8'hFF);

    // R7 via extended bit 4: timer 1 code 100
    wr(3'd0, 8'h01); wr(3'd1, 8'h10);
    wr(3'd6, 8'h02); idle(3); wr(3'd6, 8'h00);
    check("R7 t1 code 100", tl1, 8'hFF);

    // R10 set wins over clear
    wr(3'd7, 8'h00);
    wr(3'd0, 8'h02); wr(3'd1, 8'h00); wr(3'd2, 8'hFE); wr(3'd3, 8'h00);
    wr(3'd6, 8'h01); idle(1);
    wr(3'd7, 8'h00);
    wr(3'd6, 8'h00);
    check("R10 set beats clear", tfFlag[0], 1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule